// File: doc/BRIEF.md
# Compressed Block Fetch Sequencer

This block serves a read of one 64-byte unit inside an array that is stored with per-block lossless compression. A block is four units. Every block keeps its full four-unit footprint in the data array, and its compression mode lives in a separate metadata array, two bits per block. For each request the sequencer first reads the metadata byte that holds the block's mode. Then, depending on the mode, it reads either only the requested unit or every unit that holds the block's compressed form. Finally it reports the mode and the set of units read, so that a downstream decompressor knows what to combine.

A request carries a unit index and a descriptor: data base address, metadata base address and array size in units. Only one memory transaction is in flight at a time. Both the request port and the memory request port use valid/ready. A source that raises valid must hold it, and the payload, steady until the cycle in which ready is also high; that cycle is the transfer. The memory response port follows the same rule. The sequencer raises its response ready only while it waits for a response, so a memory model may present a response early and hold it. The completion report is a one-cycle pulse with no back-pressure.

Top module: `cblk_fetch_seq`

## Requirements
- R1: `req_ready` is high only when the sequencer is idle or is pulsing `done_valid`; a request is taken in a cycle where `req_valid` and `req_ready` are both high, and one may be taken in the same cycle as the previous request's completion pulse.
- R2: A request whose index is greater than or equal to `array_units` produces, in the next cycle, a completion with `done_status` = 01, `done_mode` = 00 and `done_units` = 0000, and issues no memory request.
- R3: For an in-range index, the first memory read is the metadata byte at `meta_base + (blk >> 2)`, where blk = index >> 2; the block's mode is bits [2f+1:2f] of that byte, with f = blk[1:0].
- R4: Mode 00 (stored uncompressed) reads only the requested unit u = index[1:0] at `data_base + blk*256 + u*64`, and reports `done_units` with only bit u set.
- R5: Mode 01 (two-unit compression) reads unit 0 then unit 1 of the block, whatever unit was requested, and reports `done_units` = 0011.
- R6: Mode 10 (one-unit compression) reads unit 0 of the block only and reports `done_units` = 0001.
- R7: Mode 11 is reserved: no data read follows the metadata read, and the completion carries `done_status` = 10, `done_mode` = 11, `done_units` = 0000.
- R8: Each completion is a single-cycle `done_valid` pulse with `done_status` = 00 on success and `done_mode` equal to the block's mode field; it follows the last memory response of that request.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` does not change in the next cycle.
- R10: No new memory request is raised until the response to the previous one has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_index | input | IDX_W | Unit index inside the array |
| data_base | input | AW | Byte address of unit 0 of the data array |
| meta_base | input | AW | Byte address of the metadata array |
| array_units | input | IDX_W+1 | Number of units in the array |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | AW | Byte address of the read |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_ready | output | 1 | Sequencer takes the response |
| mem_rsp_data | input | 8 | Addressed byte (used for metadata reads) |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 00 ok, 01 index out of range, 10 reserved mode |
| done_mode | output | 2 | Block mode field |
| done_units | output | 4 | Bit u set when unit u of the block was read |

## Verification
The completion pulse of one request and the acceptance of the next can fall in the same cycle, since `req_ready` is high while `done_valid` pulses. The bench provokes this by keeping `req_valid` asserted across whole sweeps of indices, including runs of consecutive out-of-range indices that complete on back-to-back cycles. It judges the overlap by pairing every completion with its own request in order and checking that each request's memory address sequence and reported mode and units match values computed from the metadata table, with the memory port stalling and delaying responses throughout.

// File: rtl/cblk_pkg.sv
package cblk_pkg;
  localparam int UNITS_PER_BLK = 4;
  localparam int UPB_LG        = 2;
  localparam int MODE_W        = 2;
  localparam int FIELDS_PER_B  = 8 / MODE_W;
  localparam int FPB_LG        = $clog2(FIELDS_PER_B);

  typedef enum logic [MODE_W-1:0] {
    CM_FULL  = 2'b00,
    CM_HALF  = 2'b01,
    CM_QUART = 2'b10,
    CM_RSVD  = 2'b11
  } cmode_e;

  typedef enum logic [1:0] {
    CS_OK    = 2'b00,
    CS_RANGE = 2'b01,
    CS_BADMD = 2'b10
  } cstat_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_MREQ,
    SQ_MWAIT,
    SQ_DREQ,
    SQ_DWAIT,
    SQ_DONE
  } seq_state_e;
endpackage

// File: rtl/cblk_addr_gen.sv
module cblk_addr_gen
  import cblk_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IDX_W   = 20,
  parameter int UNIT_LG = 6
) (
  input  logic [AW-1:0]     data_base,
  input  logic [AW-1:0]     meta_base,
  input  logic [IDX_W-1:0]  idx,
  input  logic [UPB_LG-1:0] unit_sel,
  output logic [AW-1:0]     meta_addr,
  output logic [FPB_LG-1:0] field_sel,
  output logic [UPB_LG-1:0] req_unit,
  output logic [AW-1:0]     unit_addr
);
  localparam int BLK_W  = IDX_W - UPB_LG;
  localparam int BLK_LG = UPB_LG + UNIT_LG;

  logic [BLK_W-1:0] blk;
  logic [AW-1:0]    blk_off;
  logic [AW-1:0]    unit_off;

  always_comb begin
    blk       = idx[IDX_W-1:UPB_LG];
    req_unit  = idx[UPB_LG-1:0];
    field_sel = blk[FPB_LG-1:0];
    meta_addr = meta_base + AW'(blk >> FPB_LG);
    blk_off   = AW'(blk) << BLK_LG;
    unit_off  = AW'(unit_sel) << UNIT_LG;
    unit_addr = data_base + blk_off + unit_off;
  end
endmodule

// File: rtl/cblk_mode_decode.sv
module cblk_mode_decode
  import cblk_pkg::*;
(
  input  logic [7:0]               meta_byte,
  input  logic [FPB_LG-1:0]        field_sel,
  input  logic [UPB_LG-1:0]        req_unit,
  output logic [MODE_W-1:0]        mode,
  output logic [UNITS_PER_BLK-1:0] unit_mask,
  output logic                     bad_mode
);
  logic [7:0] shifted;

  always_comb begin
    shifted   = meta_byte >> (MODE_W * int'(field_sel));
    mode      = shifted[MODE_W-1:0];
    bad_mode  = 1'b0;
    unit_mask = '0;
    unique case (cmode_e'(mode))
      CM_FULL:  unit_mask = UNITS_PER_BLK'(1) << req_unit;
      CM_HALF:  unit_mask = UNITS_PER_BLK'(2'b11);
      CM_QUART: unit_mask = UNITS_PER_BLK'(1);
      CM_RSVD:  bad_mode  = 1'b1;
      default:  bad_mode  = 1'b1;
    endcase
  end
endmodule

// File: rtl/cblk_unit_pick.sv
module cblk_unit_pick
  import cblk_pkg::*;
(
  input  logic [UNITS_PER_BLK-1:0] pend,
  output logic [UNITS_PER_BLK-1:0] pick_oh,
  output logic [UPB_LG-1:0]        pick_idx
);
  logic [UNITS_PER_BLK-1:0] below;

  for (genvar i = 0; i < UNITS_PER_BLK; i++) begin : g_pri
    if (i == 0) begin : g_first
      assign below[i] = 1'b0;
    end else begin : g_rest
      assign below[i] = below[i-1] | pend[i-1];
    end
    assign pick_oh[i] = pend[i] & ~below[i];
  end

  always_comb begin
    pick_idx = '0;
    for (int k = 0; k < UNITS_PER_BLK; k++) begin
      if (pick_oh[k]) pick_idx = UPB_LG'(k);
    end
  end
endmodule

// File: rtl/cblk_fetch_seq.sv
module cblk_fetch_seq
  import cblk_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IDX_W   = 20,
  parameter int UNIT_LG = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [IDX_W-1:0]         req_index,
  input  logic [AW-1:0]            data_base,
  input  logic [AW-1:0]            meta_base,
  input  logic [IDX_W:0]           array_units,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [AW-1:0]            mem_req_addr,
  input  logic                     mem_rsp_valid,
  output logic                     mem_rsp_ready,
  input  logic [7:0]               mem_rsp_data,
  output logic                     done_valid,
  output logic [1:0]               done_status,
  output logic [MODE_W-1:0]        done_mode,
  output logic [UNITS_PER_BLK-1:0] done_units
);
  seq_state_e               st_q;
  logic [IDX_W-1:0]         idx_q;
  logic [AW-1:0]            dbase_q;
  logic [AW-1:0]            mbase_q;
  logic [MODE_W-1:0]        mode_q;
  logic [UNITS_PER_BLK-1:0] mask_q;
  logic [UNITS_PER_BLK-1:0] pend_q;
  logic [1:0]               stat_q;
  logic                     outst_q;

  logic                     accept;
  logic                     out_of_range;
  logic [AW-1:0]            meta_addr;
  logic [AW-1:0]            unit_addr;
  logic [FPB_LG-1:0]        field_sel;
  logic [UPB_LG-1:0]        req_unit;
  logic [UPB_LG-1:0]        pick_idx;
  logic [UNITS_PER_BLK-1:0] pick_oh;
  logic [UNITS_PER_BLK-1:0] pend_left;
  logic [MODE_W-1:0]        dec_mode;
  logic [UNITS_PER_BLK-1:0] dec_mask;
  logic                     dec_bad;

  cblk_addr_gen #(.AW(AW), .IDX_W(IDX_W), .UNIT_LG(UNIT_LG)) u_addr (
    .data_base (dbase_q),
    .meta_base (mbase_q),
    .idx       (idx_q),
    .unit_sel  (pick_idx),
    .meta_addr (meta_addr),
    .field_sel (field_sel),
    .req_unit  (req_unit),
    .unit_addr (unit_addr)
  );

  cblk_mode_decode u_dec (
    .meta_byte (mem_rsp_data),
    .field_sel (field_sel),
    .req_unit  (req_unit),
    .mode      (dec_mode),
    .unit_mask (dec_mask),
    .bad_mode  (dec_bad)
  );

  cblk_unit_pick u_pick (
    .pend     (pend_q),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx)
  );

  assign req_ready     = (st_q == SQ_IDLE) || (st_q == SQ_DONE);
  assign accept        = req_valid && req_ready;
  assign out_of_range  = {1'b0, req_index} >= array_units;
  assign mem_req_valid = (st_q == SQ_MREQ) || (st_q == SQ_DREQ);
  assign mem_req_addr  = (st_q == SQ_MREQ) ? meta_addr : unit_addr;
  assign mem_rsp_ready = (st_q == SQ_MWAIT) || (st_q == SQ_DWAIT);
  assign done_valid    = (st_q == SQ_DONE);
  assign done_status   = stat_q;
  assign done_mode     = mode_q;
  assign done_units    = mask_q;
  assign pend_left     = pend_q & ~pick_oh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      idx_q   <= '0;
      dbase_q <= '0;
      mbase_q <= '0;
      mode_q  <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      stat_q  <= CS_OK;
    end else begin
      unique case (st_q)
        SQ_IDLE, SQ_DONE: begin
          if (accept) begin
            idx_q   <= req_index;
            dbase_q <= data_base;
            mbase_q <= meta_base;
            mode_q  <= '0;
            mask_q  <= '0;
            pend_q  <= '0;
            if (out_of_range) begin
              stat_q <= CS_RANGE;
              st_q   <= SQ_DONE;
            end else begin
              stat_q <= CS_OK;
              st_q   <= SQ_MREQ;
            end
          end else begin
            st_q <= SQ_IDLE;
          end
        end
        SQ_MREQ: if (mem_req_ready) st_q <= SQ_MWAIT;
        SQ_MWAIT: begin
          if (mem_rsp_valid) begin
            mode_q <= dec_mode;
            if (dec_bad) begin
              stat_q <= CS_BADMD;
              mask_q <= '0;
              st_q   <= SQ_DONE;
            end else begin
              mask_q <= dec_mask;
              pend_q <= dec_mask;
              st_q   <= SQ_DREQ;
            end
          end
        end
        SQ_DREQ: if (mem_req_ready) st_q <= SQ_DWAIT;
        SQ_DWAIT: begin
          if (mem_rsp_valid) begin
            pend_q <= pend_left;
            st_q   <= (pend_left == '0) ? SQ_DONE : SQ_DREQ;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outst_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
    else if (mem_rsp_valid && mem_rsp_ready) outst_q <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst_q); // R10
  AST_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept && out_of_range |=> done_valid && (done_status == 2'b01) && !mem_req_valid); // R2
  AST_FULL_ONE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && (done_status == 2'b00) && (done_mode == 2'b00) |-> $countones(done_units) == 1); // R4
  AST_HALF_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && (done_status == 2'b00) && (done_mode == 2'b01) |-> done_units == 4'b0011); // R5
  AST_QUART_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && (done_status == 2'b00) && (done_mode == 2'b10) |-> done_units == 4'b0001); // R6
  AST_RSVD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && (done_status == 2'b10) |-> (done_units == 4'b0000) && (done_mode == 2'b11)); // R7
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid || mem_rsp_ready |-> !req_ready); // R1
endmodule

// File: tb/sim_cblk_fetch_seq.sv
`timescale 1ns/1ps
module sim_cblk_fetch_seq;
  localparam int AW    = 32;
  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [IDX_W-1:0] req_index = '0;
  logic [AW-1:0]    data_base = '0;
  logic [AW-1:0]    meta_base = '0;
  logic [IDX_W:0]   array_units = '0;
  logic             mem_req_valid;
  logic             mem_req_ready = 1'b0;
  logic [AW-1:0]    mem_req_addr;
  logic             mem_rsp_valid = 1'b0;
  logic             mem_rsp_ready;
  logic [7:0]       mem_rsp_data = '0;
  logic             done_valid;
  logic [1:0]       done_status;
  logic [1:0]       done_mode;
  logic [3:0]       done_units;

  always #2.5 clk = ~clk;

  cblk_fetch_seq #(.AW(AW), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
    .data_base(data_base), .meta_base(meta_base), .array_units(array_units),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_status(done_status), .done_mode(done_mode),
    .done_units(done_units)
  );

  int n_chk = 0;
  int n_fail = 0;
  int issued = 0;
  int done_cnt = 0;
  int cyc = 0;
  int asize = 0;
  logic [7:0]  meta_tab [0:15];
  int          exp_st [0:255];
  int          exp_md [0:255];
  int          exp_mk [0:255];
  int          exp_n  [0:255];
  logic [31:0] exp_a  [0:255][0:4];
  logic [31:0] got_a  [0:7];
  int          got_n = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          rsp_cnt = 0;
  bit          rsp_pend = 0;
  bit          rsp_take = 0;
  logic [31:0] rsp_addr = '0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int mode_of(input int blk);
    logic [7:0] b;
    b = meta_tab[blk >> 2];
    return int'((b >> (2 * (blk & 3))) & 8'h3);
  endfunction

  task automatic expect_req(input int idx);
    int e, blk, u, m;
    e = issued;
    blk = idx >> 2;
    u = idx & 3;
    if (idx >= asize) begin
      exp_st[e] = 1; exp_md[e] = 0; exp_mk[e] = 0; exp_n[e] = 0;
    end else begin
      exp_a[e][0] = meta_base + 32'(blk >> 2);
      m = mode_of(blk);
      exp_md[e] = m;
      exp_st[e] = 0;
      case (m)
        0: begin exp_mk[e] = 1 << u; exp_n[e] = 2; exp_a[e][1] = data_base + 32'(blk * 256 + u * 64); end
        1: begin exp_mk[e] = 3; exp_n[e] = 3;
                 exp_a[e][1] = data_base + 32'(blk * 256);
                 exp_a[e][2] = data_base + 32'(blk * 256 + 64); end
        2: begin exp_mk[e] = 1; exp_n[e] = 2; exp_a[e][1] = data_base + 32'(blk * 256); end
        default: begin exp_st[e] = 2; exp_mk[e] = 0; exp_n[e] = 1; end
      endcase
    end
  endtask

  // call at a negedge; returns at the negedge after the transfer
  task automatic send(input int idx);
    expect_req(idx);
    issued++;
    req_valid = 1'b1;
    req_index = IDX_W'(idx);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_all();
    req_valid = 1'b0;
    while (done_cnt < issued) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // memory model and completion monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
        summary();
      end
      if (done_valid) begin
        int e;
        string tg;
        e = done_cnt;
        tg = (exp_st[e] == 1) ? "R2" : (exp_st[e] == 2) ? "R7" :
             (exp_md[e] == 0) ? "R4" : (exp_md[e] == 1) ? "R5" : "R6";
        chk("R8 status", 32'(done_status), 32'(exp_st[e]));
        chk("R8 mode", 32'(done_mode), 32'(exp_md[e]));
        chk(tg, 32'(done_units), 32'(exp_mk[e]));
        chk(tg, 32'(got_n), 32'(exp_n[e]));
        for (int k = 0; k < exp_n[e] && k < got_n; k++)
          chk(k == 0 ? "R3" : tg, got_a[k], exp_a[e][k]);
        got_n = 0;
        done_cnt++;
      end
      if (mem_req_valid && req_ready) chk("R1 busy", 32'(req_ready), 32'd0);
      if (mem_rsp_valid && rsp_take) mem_rsp_valid = 1'b0;
      if (rsp_pend) begin
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = ((rsp_addr - meta_base) < 16) ? meta_tab[rsp_addr - meta_base] : 8'h00;
          rsp_pend = 0;
        end else rsp_cnt--;
      end
      rsp_take = mem_rsp_valid && mem_rsp_ready;
      mem_req_ready = lfsr[0] | lfsr[3];
      if (mem_req_valid && mem_req_ready) begin
        if (rsp_pend || mem_rsp_valid) chk("R10", 32'd1, 32'd0);
        if (got_n < 8) got_a[got_n] = mem_req_addr;
        got_n++;
        rsp_pend = 1;
        rsp_cnt = int'(lfsr[5:4]);
        rsp_addr = mem_req_addr;
      end
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      for (int f = 0; f < 4; f++) b[2*f +: 2] = 2'(((4*k + f) * 3 + 1) % 4);
      meta_tab[k] = b;
    end
    for (int k = 4; k < 16; k++) meta_tab[k] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", 32'(req_ready), 32'd1);
    chk("R10 reset idle", 32'(mem_req_valid), 32'd0);
    chk("R8 reset done", 32'(done_valid), 32'd0);

    // sweep 1: gapped requests, array of 40 units, indices past the end
    data_base = 32'h1000_0000; meta_base = 32'h0000_8000; asize = 40;
    array_units = 7'(asize);
    for (int i = 0; i < 64; i++) begin
      send(i);
      wait_all();
    end

    // sweep 2: back-to-back, full array, other metadata pattern
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      for (int f = 0; f < 4; f++) b[2*f +: 2] = 2'(((4*k + f) + k) % 4);
      meta_tab[k] = b;
    end
    data_base = 32'h0040_0000; meta_base = 32'h0000_0003; asize = 64;
    array_units = 7'(asize);
    for (int i = 63; i >= 0; i--) send(i);
    wait_all();

    // sweep 3: back-to-back with mixed in-range and out-of-range indices
    asize = 10; array_units = 7'(asize);
    for (int i = 0; i < 24; i++) send((i * 5) % 20);
    wait_all();

    // sweep 4: empty array, consecutive range errors
    asize = 0; array_units = '0;
    for (int i = 0; i < 6; i++) send(i * 11);
    wait_all();

    chk("R1 all completions", 32'(done_cnt), 32'(issued));
    summary();
  end
endmodule